// File: doc/BRIEF.md
# Three-Bank Pin Controller with Interrupt Detection

This block controls three banks of 30 general-purpose pins through a flat 32-bit register port. For each pin it holds a direction bit, a pin-ownership enable and an output value. It also captures the pad level through a two-stage synchronizer, and it can detect a level or an edge condition on the pin. Registers are grouped by function. Inside each 16-byte group, the three banks sit one word apart.

Interrupt detection works per pin. A type bit chooses between level and edge detection, a polarity bit chooses which level or edge counts, and an enable bit gates the pin. Detected conditions set a sticky status bit, which software acknowledges by writing zero to it. Each bank drives its own interrupt line. A pin contributes to that line only while it is an input and its enable is set.

Top module: `pinbank_ctrl`

## Requirements
- R1: Every register holds 30 pin bits in bit positions 29..0. Bits 31 and 30 always read zero, and writing them has no effect.
- R2: The register address is group base + 4*bank, where the bank is 0, 1 or 2. The group bases are 0x00 direction, 0x20 polarity, 0x30 type, 0x40 enable, 0x50 status, 0x60 pin-ownership enable, 0x70 synchronized input (read only) and 0x80 output value. Address bits 1..0 are not decoded.
- R3: An access whose bank field (address bits 3..2) equals 3 changes no register and reads zero. An unused group also reads zero.
- R4: After reset, direction is all ones (every pin an input) and every other register is zero, including the enables. All interrupt outputs are low.
- R5: A direction bit of 1 makes the pin an input, and 0 makes it an output. The pad output enable is driven high only when the pin-ownership bit is 1 and the direction bit is 0. The pad output value always equals the output-value bit.
- R6: The synchronized input register shows the pad level two clocks after the pad settles. Writes to it are ignored.
- R7: With type bit 0 (level), the status bit is set on every clock in which the synchronized level equals the polarity bit (1 means high, 0 means low) and the enable bit is 1.
- R8: With type bit 1 (edge), the status bit is set on a rising edge when polarity is 1 and on a falling edge when polarity is 0, whatever the enable bit. An edge of the opposite direction sets nothing.
- R9: Writing 0 to a status bit clears it. Writing 1 leaves it unchanged.
- R10: When a set condition and a clearing write reach the same status bit on the same clock, the bit stays 1.
- R11: The interrupt output of bank n is the OR over its 30 pins of (direction AND status AND enable). A pin configured as an output therefore never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 90 | Pad levels, bank n uses bits 30n+29..30n |
| pad_out | output | 90 | Pad output values |
| pad_oe | output | 90 | Pad output enables |
| irq | output | 3 | Per-bank interrupt lines |

## Verification
A software acknowledge (a status write with a zero bit) can hit the same clock as a hardware set of that bit. The bench provokes this in two ways. First, it acknowledges a level-mode bit while the selected level is held, so a set is present on every clock. Second, it acknowledges an edge-mode bit with the write placed exactly on the clock where the synchronized edge reaches the status register, three clocks after the pad changes. In both cases the bench reads the status back and requires the bit to be 1. It then repeats the acknowledge with no set pending and requires a 0.

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl #(
  parameter int NBANK = 3,
  parameter int NPIN  = 30,
  parameter int AW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [AW-1:0]         bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [NBANK*NPIN-1:0] pad_in,
  output logic [NBANK*NPIN-1:0] pad_out,
  output logic [NBANK*NPIN-1:0] pad_oe,
  output logic [NBANK-1:0]      irq
);
  localparam int GW = AW - 4;
  localparam logic [GW-1:0] G_DIR = GW'(0);
  localparam logic [GW-1:0] G_POL = GW'(2);
  localparam logic [GW-1:0] G_TYP = GW'(3);
  localparam logic [GW-1:0] G_EN  = GW'(4);
  localparam logic [GW-1:0] G_STS = GW'(5);
  localparam logic [GW-1:0] G_OWN = GW'(6);
  localparam logic [GW-1:0] G_DIN = GW'(7);
  localparam logic [GW-1:0] G_OUT = GW'(8);

  typedef logic [NBANK-1:0][NPIN-1:0] bankvec_t;

  bankvec_t dir_q, pol_q, typ_q, en_q, sts_q, own_q, out_q;
  bankvec_t s1_q, s2_q, s3_q;
  bankvec_t set_v, clr_v;

  logic [GW-1:0]   grp;
  logic [1:0]      bsel;
  logic            bank_ok;
  logic [NPIN-1:0] wdat;
  logic [NPIN-1:0] rd_v;
  wire unused_bits = ^{bus_addr[1:0], bus_wdata[31:NPIN]};

  assign grp     = bus_addr[AW-1:4];
  assign bsel    = bus_addr[3:2];
  assign bank_ok = 32'(bsel) < NBANK;
  assign wdat    = bus_wdata[NPIN-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  wire bankvec_t rise = s2_q & ~s3_q;
  wire bankvec_t fall = ~s2_q & s3_q;

  assign set_v = (~typ_q & en_q & ~(s2_q ^ pol_q))
               | (typ_q & ((pol_q & rise) | (~pol_q & fall)));

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      clr_v[b] = (bus_wr && bank_ok && bsel == 2'(b) && grp == G_STS) ? ~wdat : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      pol_q <= '0;
      typ_q <= '0;
      en_q  <= '0;
      sts_q <= '0;
      own_q <= '0;
      out_q <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (bus_wr && bank_ok && bsel == 2'(b)) begin
          case (grp)
            G_DIR: dir_q[b] <= wdat;
            G_POL: pol_q[b] <= wdat;
            G_TYP: typ_q[b] <= wdat;
            G_EN:  en_q[b]  <= wdat;
            G_OWN: own_q[b] <= wdat;
            G_OUT: out_q[b] <= wdat;
            default: ;
          endcase
        end
        sts_q[b] <= (sts_q[b] & ~clr_v[b]) | set_v[b];
      end
    end
  end

  always_comb begin
    rd_v = '0;
    if (bank_ok) begin
      case (grp)
        G_DIR: rd_v = dir_q[bsel];
        G_POL: rd_v = pol_q[bsel];
        G_TYP: rd_v = typ_q[bsel];
        G_EN:  rd_v = en_q[bsel];
        G_STS: rd_v = sts_q[bsel];
        G_OWN: rd_v = own_q[bsel];
        G_DIN: rd_v = s2_q[bsel];
        G_OUT: rd_v = out_q[bsel];
        default: rd_v = '0;
      endcase
    end
  end

  assign bus_rdata = {{(32-NPIN){1'b0}}, rd_v};
  assign pad_out   = out_q;
  assign pad_oe    = own_q & ~dir_q;

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      irq[b] = |(dir_q[b] & sts_q[b] & en_q[b]);
  end
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
  parameter int NBANK = 3,
  parameter int NPIN  = 30,
  parameter int AW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [AW-1:0]              bus_addr,
  input logic [31:0]                bus_rdata,
  input logic [NBANK-1:0]           irq,
  input logic [NBANK-1:0][NPIN-1:0] dir_q,
  input logic [NBANK-1:0][NPIN-1:0] en_q,
  input logic [NBANK-1:0][NPIN-1:0] sts_q,
  input logic [NBANK-1:0][NPIN-1:0] set_v,
  input logic [NBANK-1:0][NPIN-1:0] clr_v
);
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:NPIN] == '0);

  a_r3_bank_oob: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bus_addr[3:2]) >= NBANK) |-> bus_rdata == '0);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sts_q & $past(clr_v & ~set_v)) == '0);

  a_r9_ones_keep: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sts_q & $past(sts_q & ~clr_v)) == $past(sts_q & ~clr_v));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sts_q & $past(set_v)) == $past(set_v));

  a_r11_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == '0) |-> irq == '0);

  a_r4_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> irq == '0);
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.NBANK(NBANK), .NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq),
  .dir_q(dir_q), .en_q(en_q), .sts_q(sts_q), .set_v(set_v), .clr_v(clr_v)
);

// File: tb/test_pinbank_ctrl.sv
`timescale 1ns/1ps
module test_pinbank_ctrl;
  localparam int NB = 3;
  localparam int NP = 30;
  localparam logic [29:0] FULL = 30'h3FFFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NB*NP-1:0] pads = '0;
  logic [NB*NP-1:0] pad_out, pad_oe;
  logic [NB-1:0] irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [29:0] m_reg [16][4];

  always #2.5 clk = ~clk;

  pinbank_ctrl i_pinbank_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pads),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [7:0] adr(input int g, input int b);
    return 8'((g << 4) | (b << 2));
  endfunction

  function automatic logic [31:0] exp_reg(input int g, input int b);
    if (b >= NB) return 32'h0;
    if (g == 0 || g == 2 || g == 3 || g == 4 || g == 5 || g == 6 || g == 8)
      return {2'b00, m_reg[g][b]};
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pads = '0; bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int g = 0; g < 16; g++)
      for (int b = 0; b < 4; b++)
        m_reg[g][b] = (g == 0) ? FULL : 30'h0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int groups [6] = '{0, 2, 3, 6, 8, 7};
    void'($urandom(32'hC0FFEE));
    do_reset();

    // R4 reset state, R2 map
    for (int b = 0; b < NB; b++) begin
      foreach (groups[k]) begin
        rd(adr(groups[k], b), v);
        chk($sformatf("R4 reset g%0d b%0d", groups[k], b), v, exp_reg(groups[k], b));
      end
      rd(adr(4, b), v); chk("R4 reset enable", v, 32'h0);
      rd(adr(5, b), v); chk("R4 reset status", v, 32'h0);
    end
    chk("R4 reset irq", 32'(irq), 32'h0);

    // R1 R2 R3 R6 random register traffic, pads held low
    for (int i = 0; i < 80; i++) begin
      int g = groups[$urandom % 6];
      int b = $urandom % 4;
      logic [31:0] d = $urandom;
      wr(adr(g, b), d);
      if (b < NB && g != 7) m_reg[g][b] = d[29:0];
    end
    for (int b = 0; b < 4; b++) begin
      foreach (groups[k]) begin
        rd(adr(groups[k], b), v);
        chk($sformatf("R1 R2 R3 readback g%0d b%0d", groups[k], b), v, exp_reg(groups[k], b));
      end
    end
    rd(adr(1, 0), v); chk("R3 unused group", v, 32'h0);
    for (int b = 0; b < NB; b++) begin
      chk($sformatf("R5 pad_oe b%0d", b), 32'(pad_oe[b*NP +: NP]), 32'(m_reg[6][b] & ~m_reg[0][b]));
      chk($sformatf("R5 pad_out b%0d", b), 32'(pad_out[b*NP +: NP]), 32'(m_reg[8][b]));
    end

    // R6 synchronized input
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pads = {$urandom, $urandom, $urandom};
      wait_cyc(2);
      for (int b = 0; b < NB; b++) begin
        rd(adr(7, b), v);
        chk($sformatf("R6 din b%0d", b), v, 32'(pads[b*NP +: NP]));
      end
    end

    // R7 level detection, R11 gating, R10 level collision, R9 ack
    do_reset();
    wr(adr(2, 1), 32'h20);
    wr(adr(4, 1), 32'hA0);
    @(negedge clk); pads[35] = 1'b1;
    wait_cyc(4);
    rd(adr(5, 1), v); chk("R7 level high and low set", v, 32'hA0);
    chk("R11 irq bank1", 32'(irq), 32'h2);
    wr(adr(0, 1), 32'(FULL & ~30'hA0));
    chk("R11 output pins quiet", 32'(irq), 32'h0);
    wr(adr(0, 1), 32'(FULL));
    wr(adr(5, 1), 32'h0);
    rd(adr(5, 1), v); chk("R10 level set beats ack", v, 32'hA0);
    @(negedge clk); pads[35] = 1'b0;
    wait_cyc(4);
    wr(adr(5, 1), 32'h0);
    rd(adr(5, 1), v); chk("R9 ack leaves only live level", v, 32'h80);

    // R8 edge detection, R9 ack semantics
    do_reset();
    wr(adr(3, 2), 32'h18);
    wr(adr(2, 2), 32'h18);
    @(negedge clk); pads[63] = 1'b1;
    wait_cyc(4);
    rd(adr(5, 2), v); chk("R8 rising edge sets without enable", v, 32'h08);
    chk("R11 irq needs enable", 32'(irq), 32'h0);
    wr(adr(4, 2), 32'h08);
    chk("R11 irq bank2", 32'(irq), 32'h4);
    wr(adr(5, 2), 32'hFFFFFFFF);
    rd(adr(5, 2), v); chk("R9 write one keeps", v, 32'h08);
    wr(adr(5, 2), 32'h0);
    rd(adr(5, 2), v); chk("R9 write zero clears", v, 32'h0);
    chk("R9 irq drops after ack", 32'(irq), 32'h0);
    @(negedge clk); pads[63] = 1'b0;
    wait_cyc(4);
    rd(adr(5, 2), v); chk("R8 falling ignored with pol 1", v, 32'h0);
    wr(adr(2, 2), 32'h10);
    @(negedge clk); pads[63] = 1'b1;
    wait_cyc(4);
    rd(adr(5, 2), v); chk("R8 rising ignored with pol 0", v, 32'h0);
    @(negedge clk); pads[63] = 1'b0;
    wait_cyc(4);
    rd(adr(5, 2), v); chk("R8 falling sets with pol 0", v, 32'h08);

    // R10 edge set and ack on the same clock
    wr(adr(5, 2), 32'h0);
    @(negedge clk); pads[64] = 1'b1;
    @(negedge clk);
    wr(adr(5, 2), 32'h0);
    rd(adr(5, 2), v); chk("R10 edge set beats ack", v, 32'h10);
    wr(adr(5, 2), 32'h0);
    rd(adr(5, 2), v); chk("R9 ack with no set", v, 32'h0);

    // R3 bank 3 ignored, R1 upper bits
    wr(adr(0, 3), 32'h0);
    for (int b = 0; b < NB; b++) begin
      rd(adr(0, b), v); chk("R3 bank3 write ignored", v, 32'(FULL));
    end
    rd(adr(0, 3), v); chk("R3 bank3 reads zero", v, 32'h0);
    wr(adr(8, 0), 32'hFFFFFFFF);
    rd(adr(8, 0), v); chk("R1 upper bits read zero", v, 32'(FULL));
    rd(8'h83, v); chk("R2 low address bits ignored", v, 32'(FULL));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule